// File: doc/BRIEF.md
# Quasi-Bidirectional Memory-Mapped Port Unit

This block sits on a small controller's data-memory bus and gives it three byte-addressed I/O ports. Ports A and C are bidirectional; port B is input-only. A CPU-side write to a port address loads that port's output latch. A read returns the live pad levels at the moment of the read strobe, and never the latch contents. The pad-side signals per pin are an output enable, an output value and an input level. The pad cells, pull-up resistors and CPU are outside the block.

Per-pin drive style is fixed at build time by parameters. Port A's low nibble can be push-pull or open-drain. Port A's high nibble is always open-drain. Port C is one group, either push-pull or open-drain. An open-drain pin only ever pulls low. Its latch therefore has to hold a 1 before the pin can serve as an input. Bit set, clear and complement are done by the CPU as a read of the pad levels followed by a full-byte write. A pin held low from outside at that read gets a 0 stored in its latch.

Selected open-drain pins of port A can wake a halted CPU. The pad inputs pass through a two-stage synchronizer. A low level on any enabled pin raises the wake request while the halt input is high.

Top module: `qb_gpio`

## Requirements
- R1: Port A is at address 0x12, port B at 0x14, port C at 0x16. A write to one port's address changes no other port's latch.
- R2: After reset, every output latch holds all ones. With default parameters, port A bits 3:0 then drive high (oe=1, out=1) and all open-drain pins are released (oe=0, out=0). rdata is 0 and wake_req is 0.
- R3: A push-pull pin (port A bits 3:0 by default) always has oe=1, and its out equals its latch bit.
- R4: An open-drain pin (port A bits 7:4, and port C by default) has oe=1 and out=0 when its latch bit is 0. It has oe=0 when its latch bit is 1. Its out is always 0.
- R5: A write to the port B address leaves every pad output and output enable unchanged.
- R6: A read samples the addressed port's pad inputs in the cycle rd_en is high. rdata shows the sampled value from the next cycle on and holds it until the next read.
- R7: Read-data bits above a port's width return 0; port C is 4 bits wide, so bits 7:4 read 0. A read of any address other than the three ports returns 0.
- R8: A port's latch, and so its pins, keep their value until that port's own address is written.
- R9: When the read value of a read-modify-write is written back, an open-drain pin held low from outside at the read stores a 0. That pin then drives low after the outside source lets go.
- R10: With halt high, wake_req rises on the second clock edge after an enabled open-drain port A pin goes low (bits 4 and 6 by default). Low levels on pins that are not enabled, or that are push-pull, do not raise it.
- R11: wake_req is 0 whenever halt is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| addr | input | 8 | Data-memory address |
| wdata | input | 8 | Write data |
| wr_en | input | 1 | Write strobe |
| rd_en | input | 1 | Read strobe |
| rdata | output | 8 | Registered read data |
| halt | input | 1 | CPU halted; wake-up detection armed |
| pa_in | input | 8 | Port A pad levels |
| pa_oe | output | 8 | Port A output enables |
| pa_out | output | 8 | Port A output values |
| pb_in | input | 8 | Port B pad levels |
| pc_in | input | 4 | Port C pad levels |
| pc_oe | output | 4 | Port C output enables |
| pc_out | output | 4 | Port C output values |
| wake_req | output | 1 | Wake-up request |

## Verification
A wrong latch bit shows on pa_oe or pc_oe on the cycle right after the write. A stale or wrong read shows on rdata one cycle after the strobe. A missing pull-low bit after a read-modify-write only shows after the outside source releases the pin. That makes it a test of the stored value rather than the pad. A synchronizer of the wrong depth or a wrong wake mask moves or suppresses wake_req by a cycle. The bench samples one cycle after each pad change to catch that.

// File: rtl/qb_gpio.sv
module qb_gpio #(
  parameter int          C_W           = 4,
  parameter logic [7:0]  ADDR_A        = 8'h12,
  parameter logic [7:0]  ADDR_B        = 8'h14,
  parameter logic [7:0]  ADDR_C        = 8'h16,
  parameter bit          A_LO_PUSHPULL = 1'b1,
  parameter bit          C_PUSHPULL    = 1'b0,
  parameter logic [7:0]  WAKE_MASK     = 8'h50
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic [7:0]     addr,
  input  logic [7:0]     wdata,
  input  logic           wr_en,
  input  logic           rd_en,
  output logic [7:0]     rdata,
  input  logic           halt,
  input  logic [7:0]     pa_in,
  output logic [7:0]     pa_oe,
  output logic [7:0]     pa_out,
  input  logic [7:0]     pb_in,
  input  logic [C_W-1:0] pc_in,
  output logic [C_W-1:0] pc_oe,
  output logic [C_W-1:0] pc_out,
  output logic           wake_req
);

  localparam logic [7:0]     A_PP    = A_LO_PUSHPULL ? 8'h0F : 8'h00;
  localparam logic [C_W-1:0] C_PP    = C_PUSHPULL ? '1 : '0;
  localparam logic [7:0]     WAKE_OK = WAKE_MASK & ~A_PP;

  logic [7:0]     lat_a;
  logic [C_W-1:0] lat_c;
  logic [7:0]     a_s1, a_s2;
  logic [7:0]     rd_mux;
  logic           hit_a, hit_b, hit_c;

  assign hit_a = (addr == ADDR_A);
  assign hit_b = (addr == ADDR_B);
  assign hit_c = (addr == ADDR_C);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lat_a <= '1;
      lat_c <= '1;
    end else if (wr_en) begin
      if (hit_a) lat_a <= wdata;
      if (hit_c) lat_c <= wdata[C_W-1:0];
    end
  end

  assign pa_oe  = A_PP | ~lat_a;
  assign pa_out = A_PP & lat_a;
  assign pc_oe  = C_PP | ~lat_c;
  assign pc_out = C_PP & lat_c;

  always_comb begin
    rd_mux = '0;
    if (hit_a)      rd_mux = pa_in;
    else if (hit_b) rd_mux = pb_in;
    else if (hit_c) rd_mux = 8'(pc_in);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     rdata <= '0;
    else if (rd_en) rdata <= rd_mux;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      a_s1 <= '1;
      a_s2 <= '1;
    end else begin
      a_s1 <= pa_in;
      a_s2 <= a_s1;
    end
  end

  assign wake_req = halt & |(~a_s2 & WAKE_OK);

endmodule

// File: rtl/qb_gpio_chk.sv
module qb_gpio_chk #(
  parameter int          C_W           = 4,
  parameter logic [7:0]  ADDR_A        = 8'h12,
  parameter logic [7:0]  ADDR_B        = 8'h14,
  parameter logic [7:0]  ADDR_C        = 8'h16
) (
  input logic           clk,
  input logic           rst_n,
  input logic [7:0]     addr,
  input logic [7:0]     wdata,
  input logic           wr_en,
  input logic           rd_en,
  input logic [7:0]     rdata,
  input logic           halt,
  input logic [7:0]     pb_in,
  input logic [7:0]     pa_oe,
  input logic [7:0]     pa_out,
  input logic [C_W-1:0] pc_oe,
  input logic [C_W-1:0] pc_out,
  input logic           wake_req
);

  logic unmapped;
  assign unmapped = (addr != ADDR_A) && (addr != ADDR_B) && (addr != ADDR_C);

  assert_a_write_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && addr == ADDR_A) |=> ((pa_oe & ~pa_out) == ~$past(wdata)));

  assert_c_write_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && addr == ADDR_C) |=> ((pc_oe & ~pc_out) == ~$past(wdata[C_W-1:0])));

  assert_b_write_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && addr == ADDR_B) |=>
      ($stable(pa_oe) && $stable(pa_out) && $stable(pc_oe) && $stable(pc_out)));

  assert_a_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !(wr_en && addr == ADDR_A) |=> ($stable(pa_oe) && $stable(pa_out)));

  assert_b_read_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en && addr == ADDR_B) |=> (rdata == $past(pb_in)));

  assert_rd_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_en |=> $stable(rdata));

  assert_unmapped_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en && unmapped) |=> (rdata == 8'h00));

  assert_no_wake_R11: assert property (@(posedge clk) disable iff (!rst_n)
    !halt |-> !wake_req);

endmodule

bind qb_gpio qb_gpio_chk #(.C_W(C_W), .ADDR_A(ADDR_A), .ADDR_B(ADDR_B), .ADDR_C(ADDR_C))
  u_chk (.*);

// File: tb/qb_gpio_tb.sv
module qb_gpio_tb_top;
  logic       clk = 0;
  logic       rst_n = 0;
  logic [7:0] addr = 0, wdata = 0;
  logic       wr_en = 0, rd_en = 0, halt = 0;
  logic [7:0] rdata, pa_in, pa_oe, pa_out, pb_in = 0;
  logic [3:0] pc_in, pc_oe, pc_out;
  logic       wake_req;
  logic [7:0] ext_a = 8'hFF;
  logic [3:0] ext_c = 4'hF;

  int n_run = 0, n_fail = 0;
  logic [7:0] exp_q[$];
  string      tag_q[$];

  localparam logic [7:0] A_PP = 8'h0F;
  logic [7:0] m_a = 8'hFF;
  logic [3:0] m_c = 4'hF;

  always #10 clk = ~clk;

  assign pa_in = (pa_oe & pa_out) | (~pa_oe & ext_a);
  assign pc_in = (pc_oe & pc_out) | (~pc_oe & ext_c);

  qb_gpio dut_i (.clk, .rst_n, .addr, .wdata, .wr_en, .rd_en, .rdata, .halt,
                 .pa_in, .pa_oe, .pa_out, .pb_in, .pc_in, .pc_oe, .pc_out, .wake_req);

  task automatic chk(string tag, logic [7:0] act, logic [7:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  function automatic logic [7:0] pad_a();
    return (A_PP & m_a) | (~A_PP & m_a & ext_a);
  endfunction

  function automatic logic [7:0] pad_c();
    return 8'(m_c & ext_c);
  endfunction

  task automatic wr(logic [7:0] a, logic [7:0] d);
    @(negedge clk); addr = a; wdata = d; wr_en = 1;
    if (a == 8'h12) m_a = d;
    if (a == 8'h16) m_c = d[3:0];
    @(negedge clk); wr_en = 0;
  endtask

  task automatic rd(logic [7:0] a, logic [7:0] exp, string tag);
    @(negedge clk); addr = a; rd_en = 1;
    exp_q.push_back(exp); tag_q.push_back(tag);
    @(negedge clk); rd_en = 0;
  endtask

  initial begin
    forever begin
      @(posedge clk);
      if (rd_en) begin
        @(negedge clk);
        chk(tag_q.pop_front(), rdata, exp_q.pop_front());
      end
    end
  end

  task automatic idle(int n);
    repeat (n) @(negedge clk);
  endtask

  initial begin
    #1000000;
    n_run++; n_fail++;
    $display("FAIL watchdog: actual hung expected done");
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    idle(3); rst_n = 1; idle(1);
    chk("R2 pa_oe", pa_oe, 8'h0F);
    chk("R2 pa_out", pa_out, 8'h0F);
    chk("R2 pc_oe", 8'(pc_oe), 8'h00);
    chk("R2 pc_out", 8'(pc_out), 8'h00);
    chk("R2 rdata", rdata, 8'h00);
    chk("R2 wake", 8'(wake_req), 8'h00);

    rd(8'h12, pad_a(), "R6 read A idle");

    wr(8'h12, 8'hA5);
    chk("R3 R4 pa_oe", pa_oe, 8'h5F);
    chk("R3 R4 pa_out", pa_out, 8'h05);
    rd(8'h12, pad_a(), "R6 read A after write");

    wr(8'h16, 8'h3C);
    chk("R4 pc_oe", 8'(pc_oe), 8'h03);
    chk("R4 pc_out", 8'(pc_out), 8'h00);
    chk("R1 A untouched by C write", pa_oe, 8'h5F);
    rd(8'h16, pad_c(), "R7 read C upper bits zero");

    wr(8'h14, 8'h00);
    chk("R5 pa_oe after B write", pa_oe, 8'h5F);
    chk("R5 pa_out after B write", pa_out, 8'h05);
    chk("R5 pc_oe after B write", 8'(pc_oe), 8'h03);

    pb_in = 8'h96;
    rd(8'h14, 8'h96, "R6 read B");
    pb_in = 8'h21; idle(3);
    chk("R6 rdata held", rdata, 8'h96);
    rd(8'h14, 8'h21, "R6 read B live");

    rd(8'h13, 8'h00, "R7 unmapped 0x13");
    rd(8'h00, 8'h00, "R7 unmapped 0x00");

    idle(4);
    chk("R8 A latch held", pa_out, 8'h05);
    chk("R8 C latch held", 8'(pc_oe), 8'h03);

    ext_c = 4'h7;
    wr(8'h16, 8'hFF);
    rd(8'h16, 8'h07, "R6 R7 C pad low from outside");

    wr(8'h12, 8'hFF);
    ext_a[5] = 0;
    rd(8'h12, 8'hDF, "R9 read sees external low");
    wr(8'h12, rdata | 8'h01);
    ext_a[5] = 1;
    idle(1);
    chk("R9 pa_oe bit5 driving", pa_oe, 8'h2F);
    rd(8'h12, 8'hDF, "R9 pin stays low");

    wr(8'h12, 8'hFF);
    halt = 1; idle(3);
    chk("R10 no wake idle", 8'(wake_req), 8'h00);
    ext_a[4] = 0;
    idle(1);
    chk("R10 wake after 1 edge", 8'(wake_req), 8'h00);
    idle(1);
    chk("R10 wake after 2 edges", 8'(wake_req), 8'h01);
    halt = 0; #1;
    chk("R11 wake gated by halt", 8'(wake_req), 8'h00);
    halt = 1; #1;
    chk("R10 wake rearmed", 8'(wake_req), 8'h01);
    ext_a[4] = 1; idle(3);
    chk("R10 wake clears", 8'(wake_req), 8'h00);
    ext_a[5] = 0; idle(3);
    chk("R10 disabled pin", 8'(wake_req), 8'h00);
    ext_a[5] = 1;
    wr(8'h12, 8'hFE); idle(3);
    chk("R10 push-pull pin low", 8'(wake_req), 8'h00);
    ext_a[6] = 0; idle(2);
    chk("R10 pin 6 wake", 8'(wake_req), 8'h01);
    ext_a[6] = 1; halt = 0; idle(3);

    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule